// File: doc/BRIEF.md
# SDR SDRAM Command Decoder and Bank Tracker

This block sits beside a single-data-rate SDRAM command bus and follows it on every rising clock edge. It turns the chip-select and the three strobe inputs into one command code. It keeps an open or idle state for each of four banks. From the clock-enable input and that state it works out which power mode the memory is in. Each command's bank, row or column address, auto-precharge flag and mode op-code come out registered, so a controller or monitor can read the bus as named events without decoding it again.

The block also produces a read output-enable, and the data mask can drop this enable two clock edges after it is sampled. It also gives an immediate write-mask strobe for each write beat. A protocol-error pulse marks three misuses of a bank: an access to an idle bank, an activate to an open bank, and a self-refresh entry while a row is open. Inside the block there is one two-state machine per bank and one five-state power machine. The bank states are IDLE and OPEN. IDLE goes to OPEN on a legal activate. OPEN goes to IDLE on a precharge to that bank, on a precharge-all, or when an auto-precharge burst completes. The power states are NORMAL, PRE_PD, ACT_PD, SUSPEND and SELF_REF. NORMAL moves to one of the other four when clock-enable is sampled low. Any of those four returns to NORMAL when clock-enable is sampled high.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With rst_n high, cke high, power mode NORMAL and cs_n low, {ras_n,cas_n,we_n} decodes as follows: 111 gives NOP (cmd_o 0), 011 gives ACTIVE (1), 101 gives READ (2), 100 gives WRITE (3), 010 gives PRECHARGE (4), 001 gives AUTO REFRESH (5), 000 gives LOAD MODE (7) and 110 gives BURST STOP (8). cmd_o shows the result one edge later.
- R2: When cs_n is sampled high, the command is NOP (0) whatever the strobes are, and no bank state changes.
- R3: An ACTIVE to an idle bank opens that bank (bank_open_o bit BA). It captures addr[11:0] into row_o and BA into bank_o.
- R4: A READ or WRITE to an open bank captures addr[8:0] into col_o and addr[10] into auto_pre_o, and starts a burst of BURST_LEN edges.
- R5: A PRECHARGE with addr[10] high closes every bank. With addr[10] low it closes only the bank named by BA. It also ends any burst in progress.
- R6: A LOAD MODE captures {BA, addr} into opcode_o, with BA as the two most significant bits.
- R7: In NORMAL mode, an edge with cke low enters one of four modes. It enters SELF_REF (power_o 4) when the command is AUTO REFRESH and all banks are idle. Otherwise it enters SUSPEND (3) if a burst is running, ACT_PD (2) if any bank is open, and PRE_PD (1) if none is. The edge that samples cke high returns to NORMAL (0). Outside NORMAL, commands decode as NOP and the burst count is frozen. A self-refresh entry reports cmd_o 6.
- R8: After a READ or WRITE with auto-precharge set, its bank closes on the BURST_LEN-th clock-enabled edge after the command.
- R9: proto_err_o pulses for one cycle after three kinds of command. The first is a READ or WRITE to an idle bank, which changes nothing. The second is an ACTIVE to an open bank, which leaves the bank open. The third is a self-refresh entry while any bank is open.
- R10: rd_oe_o is high while a read burst runs. It is low in the cycle after the second clock-enabled edge following one at which dqm was sampled high.
- R11: wr_mask_o follows dqm with no register delay on each write beat: the WRITE edge itself and the next BURST_LEN-1 edges.
- R12: A synchronous reset (rst_n low at an edge) makes every bank idle, puts the power mode in NORMAL and clears the command, the error pulse and the output-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable of the memory bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | 2 | Bank select |
| addr | input | 12 | Address / op-code bits |
| dqm | input | 1 | Data mask |
| cmd_o | output | 4 | Registered command code |
| bank_o | output | 2 | Bank of the last bank-targeted command |
| row_o | output | 12 | Row of the last legal ACTIVE |
| col_o | output | 9 | Column of the last legal READ/WRITE |
| auto_pre_o | output | 1 | Auto-precharge flag of the last legal READ/WRITE |
| opcode_o | output | 14 | Op-code of the last LOAD MODE |
| bank_open_o | output | 4 | One bit per bank, high when a row is open |
| power_o | output | 3 | Power mode code |
| proto_err_o | output | 1 | One-cycle protocol-error pulse |
| rd_oe_o | output | 1 | Read data output-enable |
| wr_mask_o | output | 1 | Combinational write-data mask |

## Verification
Most results are registered, so they appear one edge after the command that causes them. The bench drives inputs at the falling edge and samples 2 ns after the next rising edge. wr_mask_o is the one combinational output, so it is sampled after the falling-edge drive and before the rising edge. The dqm effect on rd_oe_o is checked on the third sample after the dqm edge, because it passes through two clock-enabled edges and then the output register. The auto-precharge close and the end of a burst after a suspend are checked on both sides of the expected edge.

// File: rtl/sdr_trk_pkg.sv
package sdr_trk_pkg;

    typedef enum logic [3:0] {
        CMD_NOP  = 4'd0,
        CMD_ACT  = 4'd1,
        CMD_RD   = 4'd2,
        CMD_WR   = 4'd3,
        CMD_PRE  = 4'd4,
        CMD_REF  = 4'd5,
        CMD_SREF = 4'd6,
        CMD_LMR  = 4'd7,
        CMD_BST  = 4'd8
    } cmd_e;

    typedef enum logic [2:0] {
        PWR_NORMAL   = 3'd0,
        PWR_PRE_PD   = 3'd1,
        PWR_ACT_PD   = 3'd2,
        PWR_SUSPEND  = 3'd3,
        PWR_SELF_REF = 3'd4
    } pwr_e;

    typedef enum logic {
        BANK_IDLE = 1'b0,
        BANK_OPEN = 1'b1
    } bank_e;

endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
    import sdr_trk_pkg::*;
(
    input  logic cke_i,
    input  logic awake_i,
    input  logic cs_n_i,
    input  logic ras_n_i,
    input  logic cas_n_i,
    input  logic we_n_i,
    output cmd_e cmd_o
);

    logic [2:0] strobes;
    assign strobes = {ras_n_i, cas_n_i, we_n_i};

    always_comb begin
        cmd_o = CMD_NOP;
        if (awake_i && !cs_n_i) begin
            if (cke_i) begin
                unique case (strobes)
                    3'b111: cmd_o = CMD_NOP;
                    3'b011: cmd_o = CMD_ACT;
                    3'b101: cmd_o = CMD_RD;
                    3'b100: cmd_o = CMD_WR;
                    3'b010: cmd_o = CMD_PRE;
                    3'b001: cmd_o = CMD_REF;
                    3'b000: cmd_o = CMD_LMR;
                    3'b110: cmd_o = CMD_BST;
                endcase
            end else if (strobes == 3'b001) begin
                cmd_o = CMD_SREF;
            end
        end
    end

endmodule

// File: rtl/sdr_bank_fsm.sv
module sdr_bank_fsm
    import sdr_trk_pkg::*;
(
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic open_req_i,
    input  logic close_req_i,
    output logic open_o
);

    bank_e state_q, state_d;

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) state_q <= BANK_IDLE;
        else          state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BANK_IDLE: if (open_req_i)  state_d = BANK_OPEN;
            BANK_OPEN: if (close_req_i) state_d = BANK_IDLE;
        endcase
    end

    assign open_o = (state_q == BANK_OPEN);

    AST_OPEN_FROM_REQ: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(open_o) |-> $past(open_req_i)); // R3

    AST_CLOSE_FROM_REQ: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $fell(open_o) |-> ($past(close_req_i) || !$past(rst_n_i))); // R5

endmodule

// File: rtl/sdr_power_fsm.sv
module sdr_power_fsm
    import sdr_trk_pkg::*;
(
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic cke_i,
    input  logic sref_i,
    input  logic all_idle_i,
    input  logic burst_busy_i,
    output pwr_e mode_o
);

    pwr_e state_q, state_d;

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) state_q <= PWR_NORMAL;
        else          state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWR_NORMAL: begin
                if (!cke_i) begin
                    if (sref_i && all_idle_i) state_d = PWR_SELF_REF;
                    else if (burst_busy_i)    state_d = PWR_SUSPEND;
                    else if (!all_idle_i)     state_d = PWR_ACT_PD;
                    else                      state_d = PWR_PRE_PD;
                end
            end
            PWR_PRE_PD, PWR_ACT_PD, PWR_SUSPEND, PWR_SELF_REF: begin
                if (cke_i) state_d = PWR_NORMAL;
            end
            default: state_d = PWR_NORMAL;
        endcase
    end

    assign mode_o = state_q;

    AST_WAKE_ON_CKE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (state_q != PWR_NORMAL && cke_i) |=> (state_q == PWR_NORMAL)); // R7

    AST_STAY_AWAKE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (state_q == PWR_NORMAL && cke_i) |=> (state_q == PWR_NORMAL)); // R7

    AST_SREF_IDLE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (state_q == PWR_SELF_REF) |-> all_idle_i); // R7

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
    import sdr_trk_pkg::*;
#(
    parameter int BA_W      = 2,
    parameter int ROW_W     = 12,
    parameter int COL_W     = 9,
    parameter int AP_BIT    = 10,
    parameter int BURST_LEN = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cke,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [BA_W-1:0]      ba,
    input  logic [ROW_W-1:0]     addr,
    input  logic                 dqm,
    output logic [3:0]           cmd_o,
    output logic [BA_W-1:0]      bank_o,
    output logic [ROW_W-1:0]     row_o,
    output logic [COL_W-1:0]     col_o,
    output logic                 auto_pre_o,
    output logic [BA_W+ROW_W-1:0] opcode_o,
    output logic [(1<<BA_W)-1:0] bank_open_o,
    output logic [2:0]           power_o,
    output logic                 proto_err_o,
    output logic                 rd_oe_o,
    output logic                 wr_mask_o
);

    localparam int NBANK = 1 << BA_W;
    localparam int OPC_W = BA_W + ROW_W;
    localparam int CNT_W = $clog2(BURST_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BURST_LEN);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    pwr_e              pwr_q;
    cmd_e              cmd;
    cmd_e              cmd_q;
    logic              awake, tick;
    logic [NBANK-1:0]  sel_oh, act_vec, pre_vec, ap_vec;
    logic              tgt_open, rw_cmd, rw_ok, act_ok, err_d;
    logic [CNT_W-1:0]  left_q, left_d;
    logic              rd_q, rd_d, ap_q, ap_d;
    logic [BA_W-1:0]   apb_q, apb_d;
    logic              busy, last_beat, interrupt, ap_fire;
    logic              dqm_q1, dqm_q2;

    assign awake = (pwr_q == PWR_NORMAL);
    assign tick  = cke && awake;

    sdr_cmd_decode u_dec (
        .cke_i   (cke),
        .awake_i (awake),
        .cs_n_i  (cs_n),
        .ras_n_i (ras_n),
        .cas_n_i (cas_n),
        .we_n_i  (we_n),
        .cmd_o   (cmd)
    );

    assign sel_oh    = NBANK'(1) << ba;
    assign tgt_open  = bank_open_o[ba];
    assign rw_cmd    = (cmd == CMD_RD) || (cmd == CMD_WR);
    assign rw_ok     = rw_cmd && tgt_open;
    assign act_ok    = (cmd == CMD_ACT) && !tgt_open;
    assign err_d     = (rw_cmd && !tgt_open) || ((cmd == CMD_ACT) && tgt_open)
                     || ((cmd == CMD_SREF) && (|bank_open_o));

    assign busy      = (left_q != '0);
    assign last_beat = tick && (left_q == CNT_ONE);
    assign interrupt = rw_ok || (cmd == CMD_BST) || (cmd == CMD_PRE);
    assign ap_fire   = ap_q && (last_beat || interrupt);

    assign act_vec = act_ok ? sel_oh : '0;
    assign pre_vec = (cmd == CMD_PRE) ? (addr[AP_BIT] ? '1 : sel_oh) : '0;
    assign ap_vec  = ap_fire ? (NBANK'(1) << apb_q) : '0;

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        sdr_bank_fsm u_bank (
            .clk_i       (clk),
            .rst_n_i     (rst_n),
            .open_req_i  (act_vec[g]),
            .close_req_i (pre_vec[g] | ap_vec[g]),
            .open_o      (bank_open_o[g])
        );
    end

    sdr_power_fsm u_pwr (
        .clk_i        (clk),
        .rst_n_i      (rst_n),
        .cke_i        (cke),
        .sref_i       (cmd == CMD_SREF),
        .all_idle_i   (bank_open_o == '0),
        .burst_busy_i (busy),
        .mode_o       (pwr_q)
    );

    // burst tracker next state
    always_comb begin
        left_d = left_q;
        rd_d   = rd_q;
        ap_d   = ap_q;
        apb_d  = apb_q;
        if (rw_ok) begin
            left_d = CNT_FULL;
            rd_d   = (cmd == CMD_RD);
            ap_d   = addr[AP_BIT];
            apb_d  = ba;
        end else if ((cmd == CMD_BST) || (cmd == CMD_PRE)) begin
            left_d = '0;
            ap_d   = 1'b0;
        end else if (tick && busy) begin
            left_d = left_q - CNT_ONE;
            if (left_q == CNT_ONE) ap_d = 1'b0;
        end
    end

    assign wr_mask_o = dqm && ((rw_ok && (cmd == CMD_WR))
                     || (tick && busy && !rd_q && (left_q > CNT_ONE)));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q       <= CMD_NOP;
            bank_o      <= '0;
            row_o       <= '0;
            col_o       <= '0;
            auto_pre_o  <= 1'b0;
            opcode_o    <= '0;
            proto_err_o <= 1'b0;
            rd_oe_o     <= 1'b0;
            dqm_q1      <= 1'b0;
            dqm_q2      <= 1'b0;
            left_q      <= '0;
            rd_q        <= 1'b0;
            ap_q        <= 1'b0;
            apb_q       <= '0;
        end else begin
            cmd_q       <= cmd;
            proto_err_o <= err_d;
            left_q      <= left_d;
            rd_q        <= rd_d;
            ap_q        <= ap_d;
            apb_q       <= apb_d;
            if ((cmd == CMD_ACT) || rw_cmd || (cmd == CMD_PRE)) bank_o <= ba;
            if (act_ok) row_o <= addr;
            if (rw_ok) begin
                col_o      <= addr[COL_W-1:0];
                auto_pre_o <= addr[AP_BIT];
            end
            if (cmd == CMD_LMR) opcode_o <= {ba, addr};
            if (tick) begin
                dqm_q1 <= dqm;
                dqm_q2 <= dqm_q1;
            end
            rd_oe_o <= (left_d != '0) && rd_d && !dqm_q2;
        end
    end

    assign cmd_o   = cmd_q;
    assign power_o = pwr_q;

    AST_CS_HOLDS_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !ap_q) |=> $stable(bank_open_o)); // R2

    AST_ROW_ONLY_ON_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_ACT) |=> $stable(row_o)); // R3

    AST_NO_OE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rd_q) |-> !rd_oe_o); // R10

    AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err_o |-> ($past(cmd) != CMD_NOP)); // R9

endmodule

// File: tb/sdram_cmd_tracker_tb_top.sv
`timescale 1ns/1ps
module sdram_cmd_tracker_tb_top;

    localparam logic [2:0] S_NOP = 3'b111, S_ACT = 3'b011, S_RD = 3'b101,
                           S_WR = 3'b100, S_PRE = 3'b010, S_REF = 3'b001,
                           S_LMR = 3'b000, S_BST = 3'b110;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, dqm = 1'b0;
    logic [1:0]  ba = '0;
    logic [11:0] addr = '0;
    logic [3:0]  cmd_o;
    logic [1:0]  bank_o;
    logic [11:0] row_o;
    logic [8:0]  col_o;
    logic        auto_pre_o;
    logic [13:0] opcode_o;
    logic [3:0]  bank_open_o;
    logic [2:0]  power_o;
    logic        proto_err_o, rd_oe_o, wr_mask_o;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    sdram_cmd_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .dqm(dqm),
        .cmd_o(cmd_o), .bank_o(bank_o), .row_o(row_o), .col_o(col_o),
        .auto_pre_o(auto_pre_o), .opcode_o(opcode_o), .bank_open_o(bank_open_o),
        .power_o(power_o), .proto_err_o(proto_err_o), .rd_oe_o(rd_oe_o),
        .wr_mask_o(wr_mask_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drv(input logic c_cs, input logic [2:0] s, input logic [1:0] b,
                       input logic [11:0] a, input logic c_cke, input logic d);
        @(negedge clk);
        cs_n = c_cs; {ras_n, cas_n, we_n} = s; ba = b; addr = a; cke = c_cke; dqm = d;
    endtask

    task automatic stepx();
        @(posedge clk);
        #2;
    endtask

    task automatic op(input logic c_cs, input logic [2:0] s, input logic [1:0] b,
                      input logic [11:0] a, input logic c_cke, input logic d);
        drv(c_cs, s, b, a, c_cke, d);
        stepx();
    endtask

    initial begin
        #(20 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        op(1, S_NOP, 0, 0, 1, 0);
        op(1, S_NOP, 0, 0, 1, 0);
        chk("R12 reset cmd", int'(cmd_o), 0);
        chk("R12 reset power", int'(power_o), 0);
        chk("R12 reset banks", int'(bank_open_o), 0);
        chk("R12 reset err", int'(proto_err_o), 0);
        chk("R12 reset oe", int'(rd_oe_o), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: chip select high masks every strobe pattern
        for (int s = 0; s < 8; s++) begin
            op(1, 3'(s), 2'(s), 12'h400, 1, 0);
            chk("R2 cmd masked", int'(cmd_o), 0);
            chk("R2 banks unchanged", int'(bank_open_o), 0);
        end

        // R1 R3 R9: open each bank, then reopen it
        for (int b = 0; b < 4; b++) begin
            op(0, S_ACT, 2'(b), 12'(b * 12'h123 + 7), 1, 0);
            chk("R1 act code", int'(cmd_o), 1);
            chk("R3 bank", int'(bank_o), b);
            chk("R3 row", int'(row_o), b * 12'h123 + 7);
            chk("R3 open mask", int'(bank_open_o), (1 << (b + 1)) - 1);
            chk("R9 no err", int'(proto_err_o), 0);
            op(0, S_ACT, 2'(b), 12'hFFF, 1, 0);
            chk("R9 act on open", int'(proto_err_o), 1);
            chk("R9 row kept", int'(row_o), b * 12'h123 + 7);
        end
        op(1, S_PRE, 0, 12'h400, 1, 0);
        chk("R2 banks held", int'(bank_open_o), 4'hF);

        // R4 R5 R10
        op(0, S_RD, 3, 12'h0F0, 1, 0);
        chk("R1 read code", int'(cmd_o), 2);
        chk("R4 col", int'(col_o), 12'h0F0);
        chk("R4 ap clear", int'(auto_pre_o), 0);
        chk("R10 oe on read", int'(rd_oe_o), 1);
        op(0, S_PRE, 2, 12'h000, 1, 0);
        chk("R1 pre code", int'(cmd_o), 4);
        chk("R5 single close", int'(bank_open_o), 4'b1011);
        chk("R5 burst ended", int'(rd_oe_o), 0);
        op(0, S_RD, 2, 12'h011, 1, 0);
        chk("R9 read idle", int'(proto_err_o), 1);
        chk("R9 read idle code", int'(cmd_o), 2);
        chk("R9 col kept", int'(col_o), 12'h0F0);
        op(0, S_WR, 2, 12'h012, 1, 0);
        chk("R9 write idle", int'(proto_err_o), 1);
        chk("R1 write code", int'(cmd_o), 3);
        op(0, S_PRE, 1, 12'h400, 1, 0);
        chk("R5 close all", int'(bank_open_o), 0);

        // R1 R6
        op(0, S_REF, 0, 0, 1, 0);
        chk("R1 refresh code", int'(cmd_o), 5);
        op(0, S_BST, 0, 0, 1, 0);
        chk("R1 stop code", int'(cmd_o), 8);
        op(0, S_NOP, 0, 0, 1, 0);
        chk("R1 nop code", int'(cmd_o), 0);
        for (int i = 0; i < 8; i++) begin
            op(0, S_LMR, 2'(i), 12'(i * 12'h2A5), 1, 0);
            chk("R1 lmr code", int'(cmd_o), 7);
            chk("R6 opcode", int'(opcode_o), ((i % 4) << 12) | ((i * 12'h2A5) & 12'hFFF));
        end

        // R8 R10: auto-precharge read with a dqm pulse
        op(0, S_ACT, 1, 12'hABC, 1, 0);
        chk("R3 row b1", int'(row_o), 12'hABC);
        op(0, S_RD, 1, 12'h6A5, 1, 0);
        chk("R4 col masked", int'(col_o), 12'h0A5);
        chk("R4 ap set", int'(auto_pre_o), 1);
        chk("R10 oe start", int'(rd_oe_o), 1);
        op(0, S_NOP, 0, 0, 1, 1);
        chk("R10 oe before delay", int'(rd_oe_o), 1);
        op(0, S_NOP, 0, 0, 1, 0);
        chk("R10 oe still on", int'(rd_oe_o), 1);
        op(0, S_NOP, 0, 0, 1, 0);
        chk("R10 oe masked", int'(rd_oe_o), 0);
        chk("R8 open before end", int'(bank_open_o), 4'b0010);
        op(0, S_NOP, 0, 0, 1, 0);
        chk("R8 closed at end", int'(bank_open_o), 0);
        chk("R10 oe off", int'(rd_oe_o), 0);

        // R11: write mask
        op(0, S_ACT, 0, 12'h055, 1, 0);
        drv(0, S_WR, 0, 12'h010, 1, 1);
        #1 chk("R11 mask on write edge", int'(wr_mask_o), 1);
        stepx();
        chk("R10 no oe on write", int'(rd_oe_o), 0);
        drv(0, S_NOP, 0, 0, 1, 0);
        #1 chk("R11 mask follows dqm low", int'(wr_mask_o), 0);
        stepx();
        drv(0, S_NOP, 0, 0, 1, 1);
        #1 chk("R11 mask beat 3", int'(wr_mask_o), 1);
        stepx();
        drv(0, S_NOP, 0, 0, 1, 1);
        #1 chk("R11 mask beat 4", int'(wr_mask_o), 1);
        stepx();
        drv(0, S_NOP, 0, 0, 1, 1);
        #1 chk("R11 no mask after burst", int'(wr_mask_o), 0);
        stepx();
        op(0, S_NOP, 0, 0, 1, 0);

        // R7: power modes
        op(0, S_NOP, 0, 0, 0, 0);
        chk("R7 active pd", int'(power_o), 2);
        op(0, S_ACT, 3, 12'h321, 0, 0);
        chk("R7 ignored in pd", int'(bank_open_o), 4'b0001);
        chk("R7 nop in pd", int'(cmd_o), 0);
        op(0, S_NOP, 0, 0, 1, 0);
        chk("R7 wake", int'(power_o), 0);
        op(0, S_PRE, 0, 12'h400, 1, 0);
        op(0, S_NOP, 0, 0, 0, 0);
        chk("R7 precharge pd", int'(power_o), 1);
        op(0, S_NOP, 0, 0, 1, 0);
        chk("R7 wake 2", int'(power_o), 0);
        op(0, S_ACT, 2, 12'h111, 1, 0);
        op(0, S_RD, 2, 12'h003, 1, 0);
        chk("R10 oe read b2", int'(rd_oe_o), 1);
        for (int k = 0; k < 3; k++) begin
            op(0, S_NOP, 0, 0, 0, 0);
            chk("R7 suspend", int'(power_o), 3);
            chk("R7 oe frozen", int'(rd_oe_o), 1);
        end
        op(0, S_NOP, 0, 0, 1, 0);
        chk("R7 suspend exit", int'(power_o), 0);
        for (int k = 1; k <= 4; k++) begin
            op(0, S_NOP, 0, 0, 1, 0);
            chk("R7 burst resumes", int'(rd_oe_o), (k < 4) ? 1 : 0);
        end
        op(0, S_PRE, 0, 12'h400, 1, 0);
        op(0, S_REF, 0, 0, 0, 0);
        chk("R7 sref code", int'(cmd_o), 6);
        chk("R7 self refresh", int'(power_o), 4);
        op(0, S_NOP, 0, 0, 0, 0);
        chk("R7 sref held", int'(power_o), 4);
        op(0, S_NOP, 0, 0, 1, 0);
        chk("R7 sref exit", int'(power_o), 0);
        op(0, S_ACT, 0, 12'h777, 1, 0);
        op(0, S_REF, 0, 0, 0, 0);
        chk("R9 sref with open row", int'(proto_err_o), 1);
        chk("R7 sref refused", int'(power_o), 2);
        op(0, S_NOP, 0, 0, 1, 0);

        // R12: reset from a sleep mode with a row open
        op(0, S_NOP, 0, 0, 0, 0);
        chk("R7 pd before reset", int'(power_o), 2);
        @(negedge clk);
        rst_n = 1'b0; cke = 1'b1;
        stepx();
        chk("R12 banks idle", int'(bank_open_o), 0);
        chk("R12 power normal", int'(power_o), 0);
        chk("R12 cmd cleared", int'(cmd_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        op(0, S_NOP, 0, 0, 1, 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule